// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core is allowed to fetch. It looks at one status code per thread, a mask of active threads, and two occupancy counts per thread (instruction queue and load/store queue). A policy select input chooses how the winner is picked. The result is a thread id and a valid bit. Both are combinational from the inputs and from the internal priority order.

For the round-robin policy the block keeps an ordered list of thread ids. The winner is the first eligible entry, scanning from the front. When the fetch stage takes the grant (`grant_i` high while the round-robin selection is valid), the block moves the winning id to the back of the list. The other entries keep their relative order. The occupancy policies select the least-loaded eligible thread. The single-thread policy is legal only when the block is built with one thread. When nothing can be selected, the valid bit is low and fetch stops for that cycle.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its active bit is set and its 3-bit status code is 0 (running), 1 (idle) or 4 (access complete). Codes 2, 3, 5, 6 and 7 make it ineligible, and an ineligible thread is never output.
- R2: Under the round-robin policy, the output is the first eligible thread found when the priority list is scanned from its front.
- R3: After reset the priority list holds the thread ids in ascending order, with thread 0 at the front.
- R4: On a rising clock edge where `grant_i` is high and a round-robin selection is valid, the selected id moves to the back of the list and the others keep their relative order. Without such a grant the list does not change.
- R5: When no thread can be selected, `valid_o` is 0 and `tid_o` is 0.
- R6: The policy codes are 0 single-thread, 1 round-robin, 2 branch-count, 3 instruction-queue count and 4 load/store-queue count. Code 2 and codes 5 to 7 never produce a selection.
- R7: Under policy 3, the output is the eligible thread with the lowest instruction-queue count. A tie goes to the lower thread id.
- R8: Under policy 4, the output is the eligible thread with the lowest load/store-queue count, with ties going to the lower id. Instruction-queue counts have no effect under this policy.
- R9: With more than one thread configured, policy 0 produces no selection.
- R10: With one thread configured, thread 0 is output whenever it is eligible, whatever the policy. Otherwise nothing is output.
- R11: A grant taken while a policy other than round-robin is in force leaves the priority list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 3 | Selection policy code |
| active_i | input | NUM_THREADS | Active-thread mask |
| status_i | input | 3*NUM_THREADS | Per-thread status codes; thread t at bits [3t+2:3t] |
| iq_cnt_i | input | CNT_W*NUM_THREADS | Per-thread instruction-queue occupancy |
| lsq_cnt_i | input | CNT_W*NUM_THREADS | Per-thread load/store-queue occupancy |
| grant_i | input | 1 | Fetch stage consumed the current selection |
| tid_o | output | TID_W | Selected thread id |
| valid_o | output | 1 | Selection is valid |

## Verification
Round-robin is driven with a series of eligibility masks: a single eligible thread, alternating threads, all threads, and threads at both ends of the list. Grants are taken between the masks, so the rotation order is compared with an independent list model. Cycles without a grant show that the list holds. Each status code is tried on its own, which separates the eligible codes from the blocking ones. For the occupancy policies, the two count sets are chosen to disagree, and ties are placed at both low and high ids. This shows which count is used and which way a tie is broken. Reserved policy codes, the single-thread policy with several threads, and a one-thread build complete the set.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    ST_RUNNING  = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SQUASH   = 3'd2,
    ST_BLOCKED  = 3'd3,
    ST_ACC_DONE = 3'd4,
    ST_WAIT_RSP = 3'd5,
    ST_WAIT_RTY = 3'd6,
    ST_QUIESCE  = 3'd7
  } thr_status_e;

  typedef enum logic [2:0] {
    POL_SINGLE = 3'd0,
    POL_RR     = 3'd1,
    POL_BRANCH = 3'd2,
    POL_IQ     = 3'd3,
    POL_LSQ    = 3'd4
  } fetch_pol_e;

  localparam int unsigned ST_W = 3;
endpackage

// File: rtl/fts_elig.sv
module fts_elig
  import fts_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0]      active_i,
  input  logic [ST_W*NUM_THREADS-1:0] status_i,
  output logic [NUM_THREADS-1:0]      elig_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thr_status_e st;
    assign st = thr_status_e'(status_i[t*ST_W +: ST_W]);
    assign elig_o[t] = active_i[t] &&
                       (st == ST_RUNNING || st == ST_IDLE || st == ST_ACC_DONE);
  end
endmodule

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned TID_W       = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] elig_i,
  input  logic                   rotate_i,
  output logic [TID_W-1:0]       pick_o,
  output logic                   found_o
);
  localparam int unsigned POS_W = TID_W;

  logic [TID_W-1:0] order_q [NUM_THREADS];
  logic [TID_W-1:0] order_d [NUM_THREADS];
  logic [POS_W-1:0] pos;

  // first eligible entry from the front
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    pos     = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (!found_o && elig_i[order_q[k]]) begin
        found_o = 1'b1;
        pick_o  = order_q[k];
        pos     = POS_W'(k);
      end
    end
  end

  // remove picked entry, close the gap, append it at the back
  always_comb begin
    for (int k = 0; k < NUM_THREADS; k++) order_d[k] = order_q[k];
    if (rotate_i && found_o) begin
      for (int k = 0; k < NUM_THREADS - 1; k++)
        if (POS_W'(k) >= pos) order_d[k] = order_q[k+1];
      order_d[NUM_THREADS-1] = pick_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_THREADS; k++) order_q[k] <= TID_W'(k);
    end else begin
      for (int k = 0; k < NUM_THREADS; k++) order_q[k] <= order_d[k];
    end
  end

  logic [NUM_THREADS-1:0] seen;
  logic [NUM_THREADS*TID_W-1:0] order_flat;
  always_comb begin
    seen = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      seen[order_q[k]] = 1'b1;
      order_flat[k*TID_W +: TID_W] = order_q[k];
    end
  end

  // list stays a permutation (ascending start, R3)
  p_perm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen) == NUM_THREADS);
  p_rot_back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_i && found_o) |=> order_q[NUM_THREADS-1] == $past(pick_o));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rotate_i |=> $stable(order_flat));
endmodule

// File: rtl/fts_min_occ.sv
module fts_min_occ #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned TID_W       = 2
) (
  input  logic [NUM_THREADS-1:0]       elig_i,
  input  logic [CNT_W*NUM_THREADS-1:0] cnt_i,
  output logic [TID_W-1:0]             pick_o,
  output logic                         found_o
);
  logic [CNT_W-1:0] best;

  // strict compare keeps the lower id on ties
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    best    = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (elig_i[i] && (!found_o || cnt_i[i*CNT_W +: CNT_W] < best)) begin
        found_o = 1'b1;
        pick_o  = TID_W'(i);
        best    = cnt_i[i*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fts_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned CNT_W       = 6,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   policy_i,
  input  logic [NUM_THREADS-1:0]       active_i,
  input  logic [ST_W*NUM_THREADS-1:0]  status_i,
  input  logic [CNT_W*NUM_THREADS-1:0] iq_cnt_i,
  input  logic [CNT_W*NUM_THREADS-1:0] lsq_cnt_i,
  input  logic                         grant_i,
  output logic [TID_W-1:0]             tid_o,
  output logic                         valid_o
);
  logic [NUM_THREADS-1:0]       elig;
  logic [CNT_W*NUM_THREADS-1:0] occ_sel;
  logic [TID_W-1:0]             rr_pick, occ_pick;
  logic                         rr_found, occ_found, rotate;
  fetch_pol_e                   pol;

  assign pol = fetch_pol_e'(policy_i);

  fts_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .active_i (active_i),
    .status_i (status_i),
    .elig_o   (elig)
  );

  assign rotate = grant_i && (pol == POL_RR) && rr_found && (NUM_THREADS > 1);

  fts_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .elig_i   (elig),
    .rotate_i (rotate),
    .pick_o   (rr_pick),
    .found_o  (rr_found)
  );

  assign occ_sel = (pol == POL_LSQ) ? lsq_cnt_i : iq_cnt_i;

  fts_min_occ #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_occ (
    .elig_i  (elig),
    .cnt_i   (occ_sel),
    .pick_o  (occ_pick),
    .found_o (occ_found)
  );

  if (NUM_THREADS == 1) begin : g_one
    assign valid_o = elig[0];
    assign tid_o   = '0;
  end else begin : g_multi
    always_comb begin
      valid_o = 1'b0;
      tid_o   = '0;
      unique case (pol)
        POL_RR: begin
          valid_o = rr_found;
          tid_o   = rr_found ? rr_pick : '0;
        end
        POL_IQ, POL_LSQ: begin
          valid_o = occ_found;
          tid_o   = occ_found ? occ_pick : '0;
        end
        default: ;  // single (illegal here), branch, reserved
      endcase
    end
  end

  p_valid_elig_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig[tid_o]);
  p_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> tid_o == '0);
  p_branch_none_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_THREADS > 1 && policy_i == 3'd2) |-> !valid_o);
endmodule

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb;
  localparam int CLK_P = 10;
  localparam int N = 4;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0;
  logic [2:0] pol = 3'd1;
  logic [N-1:0] act = '1;
  logic [3*N-1:0] st = '0;
  logic [CW*N-1:0] iq = '0, lsq = '0;
  logic grant = 0;
  logic [1:0] tid;
  logic valid;
  logic [2:0] st1 = '0;
  logic act1 = 1'b1;
  logic [CW-1:0] c1 = '0;
  logic tid1, valid1;

  int checks = 0, errors = 0;
  int ml [N];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fetch_thread_sel #(.NUM_THREADS(N), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .active_i(act),
    .status_i(st), .iq_cnt_i(iq), .lsq_cnt_i(lsq), .grant_i(grant),
    .tid_o(tid), .valid_o(valid));

  fetch_thread_sel #(.NUM_THREADS(1), .CNT_W(CW)) u_dut_one (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .active_i(act1),
    .status_i(st1), .iq_cnt_i(c1), .lsq_cnt_i(c1), .grant_i(grant),
    .tid_o(tid1), .valid_o(valid1));

  task automatic chk(string req, int at, int av, int et, int ev);
    checks++;
    if (at != et || av != ev) begin
      errors++;
      $display("FAIL %s: tid=%0d valid=%0d expected tid=%0d valid=%0d", req, at, av, et, ev);
    end
  endtask

  function automatic bit b_elig(int t);
    logic [2:0] s = st[t*3 +: 3];
    return act[t] && (s == 3'd0 || s == 3'd1 || s == 3'd4);
  endfunction

  function automatic int rr_exp();
    for (int k = 0; k < N; k++) if (b_elig(ml[k])) return ml[k];
    return -1;
  endfunction

  function automatic void m_rotate(int t);
    int p = 0;
    for (int k = 0; k < N; k++) if (ml[k] == t) p = k;
    for (int k = p; k < N - 1; k++) ml[k] = ml[k+1];
    ml[N-1] = t;
  endfunction

  task automatic set_mask(logic [N-1:0] m);
    for (int t = 0; t < N; t++) st[t*3 +: 3] = m[t] ? 3'd0 : 3'd3;
  endtask

  task automatic settle(); @(negedge clk); #1; endtask

  task automatic pulse();
    grant = 1; @(posedge clk); @(negedge clk); grant = 0; #1;
  endtask

  task automatic chk_rr(string req);
    int e = rr_exp();
    chk(req, tid, valid, e < 0 ? 0 : e, e >= 0);
  endtask

  task automatic t_reset_r3();
    for (int k = 0; k < N; k++) ml[k] = k;
    pol = 3'd1; act = '1; set_mask('1); settle();
    chk("R3 reset order front", tid, valid, 0, 1);
    for (int i = 0; i < N + 1; i++) begin
      chk("R3 ascending walk", tid, valid, i % N, 1);
      m_rotate(i % N); pulse();
    end
  endtask

  task automatic t_elig_r1();
    pol = 3'd1; set_mask('0);
    for (int c = 0; c < 8; c++) begin
      st[2*3 +: 3] = 3'(c); settle();
      chk_rr("R1 status code");
    end
    st[2*3 +: 3] = 3'd0; act[2] = 0; settle();
    chk("R1 inactive thread", tid, valid, 0, 0);
    act = '1;
  endtask

  task automatic t_none_r5();
    set_mask('0);
    pol = 3'd1; settle(); chk("R5 none rr", tid, valid, 0, 0);
    pol = 3'd3; settle(); chk("R5 none iq", tid, valid, 0, 0);
    pol = 3'd1;
  endtask

  task automatic t_rr_r2_r4();
    logic [N-1:0] pats [6] = '{4'b0100, 4'b1010, 4'b1111, 4'b0011, 4'b1001, 4'b1111};
    pol = 3'd1;
    foreach (pats[i]) begin
      set_mask(pats[i]); settle();
      chk_rr("R2 first eligible");
      if (rr_exp() >= 0) m_rotate(rr_exp());
      pulse();
      chk_rr("R4 after rotation");
    end
    set_mask('1); settle(); chk_rr("R4 hold");
    repeat (3) @(negedge clk); #1; chk_rr("R4 hold no grant");
  endtask

  task automatic t_iq_r7();
    pol = 3'd3; set_mask('1);
    iq  = {6'd9, 6'd3, 6'd3, 6'd5};
    lsq = {6'd0, 6'd9, 6'd9, 6'd9};
    settle(); chk("R7 lowest iq tie low id", tid, valid, 1, 1);
    st[1*3 +: 3] = 3'd3; settle(); chk("R7 skip ineligible", tid, valid, 2, 1);
    iq = {6'd3, 6'd9, 6'd9, 6'd9}; set_mask('1); settle();
    chk("R7 highest id lowest", tid, valid, 3, 1);
  endtask

  task automatic t_lsq_r8();
    pol = 3'd4; set_mask('1);
    iq  = {6'd9, 6'd9, 6'd9, 6'd0};
    lsq = {6'd2, 6'd2, 6'd7, 6'd7};
    settle(); chk("R8 lowest lsq tie", tid, valid, 2, 1);
    lsq = {6'd1, 6'd1, 6'd1, 6'd1}; settle(); chk("R8 all tie", tid, valid, 0, 1);
  endtask

  task automatic t_pol_r6_r9();
    set_mask('1);
    pol = 3'd2; settle(); chk("R6 branch none", tid, valid, 0, 0);
    for (int p = 5; p < 8; p++) begin
      pol = 3'(p); settle(); chk("R6 reserved code", tid, valid, 0, 0);
    end
    pol = 3'd0; settle(); chk("R9 single illegal", tid, valid, 0, 0);
  endtask

  task automatic t_grant_nonrr_r11();
    set_mask('1); pol = 3'd3; iq = {6'd1, 6'd2, 6'd3, 6'd4};
    settle();
    repeat (3) pulse();
    pol = 3'd1; settle(); chk_rr("R11 list unchanged");
  endtask

  task automatic t_one_r10();
    st1 = 3'd0; act1 = 1;
    for (int p = 0; p < 8; p++) begin
      pol = 3'(p); settle(); chk("R10 one thread", int'(tid1), valid1, 0, 1);
    end
    st1 = 3'd6; settle(); chk("R10 one thread blocked", int'(tid1), valid1, 0, 0);
    pol = 3'd1;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_r3();
    t_elig_r1();
    t_none_r5();
    t_rr_r2_r4();
    t_iq_r7();
    t_lsq_r8();
    t_pol_r6_r9();
    t_grant_nonrr_r11();
    t_one_r10();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule